// File: doc/BRIEF.md
# Sampling ADC serial readout controller

This controller runs a serial sampling converter from the logic side. When it accepts a start request, it raises a conversion strobe for one serial-clock period. It then generates a frame of serial clocks derived from the system clock. On each falling serial-clock edge it samples the converter's data line. Data bits only begin at the third rising serial-clock edge after the strobe rises. They arrive most significant bit first and sit right-justified in the frame.

The result is 14 bits wide, or 12 bits when the mode input is high at the start request. It is returned as a zero-extended 16-bit word with a one-cycle valid pulse. A busy output covers the whole strobe and frame. Start requests seen while busy have no effect.

The serial clock period is `2*HALF_DIV` system clocks, with `HALF_DIV >= 1`. The frame length `FRAME_CLKS` must be at least 16.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, conv_o, sck_o, busy_o and valid_o are 0 and data_o is 0.
- R2: An accepted start raises conv_o, with sck_o held low, for exactly 2*HALF_DIV system clocks, once per accepted start.
- R3: After the strobe, sck_o makes exactly FRAME_CLKS rising edges. Each period is HALF_DIV clocks high followed by HALF_DIV clocks low, and the first rising edge coincides with the fall of conv_o.
- R4: Counting rising sck_o edges from 1 after conv_o rises, the data bit driven after rising edge k is sampled at falling edge k. Sampling uses falling edges 3 onward, most significant bit first. Values on the line at edges 1 and 2 are ignored.
- R5: With mode12_i=0 at start, data_o[13:0] holds the 14 bits sampled at falling edges 3..16, and data_o[15:14] is 0.
- R6: With mode12_i=1 at start, data_o[11:0] holds the 12 bits sampled at falling edges 3..14, data_o[15:12] is 0, and the line after edge 14 is ignored.
- R7: valid_o is high for exactly one system clock per frame: the cycle after the last data bit is sampled. data_o holds the new result from that cycle on.
- R8: busy_o is high from the cycle after an accepted start until the frame ends. A start request while busy_o is high starts no new strobe or frame.
- R9: mode12_i is sampled only when a start is accepted; changing it during a frame does not alter that frame's width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and readout |
| mode12_i | input | 1 | 1 selects 12-bit result, 0 selects 14-bit |
| sdo_i | input | 1 | Serial data line from the converter |
| conv_o | output | 1 | Conversion-start strobe |
| sck_o | output | 1 | Generated serial clock |
| busy_o | output | 1 | Strobe or frame in progress |
| data_o | output | 16 | Right-justified, zero-extended result |
| valid_o | output | 1 | One-cycle pulse when data_o is updated |

## Verification
The bench models the converter. It drives random garbage on the line at the two leading edges and after the last data bit, so a controller that starts sampling one edge early, or keeps shifting past the last bit, returns a shifted or polluted word. All-ones patterns in both widths expose missing zero extension in the upper bits. A start pulse in mid-frame, and a mode flip just after the start, catch a design that restarts the frame or reads the width live. The bench also counts strobe cycles, serial-clock edges and valid cycles per frame, which exposes off-by-one errors in the divider or frame length.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_CLKS = 16,
  parameter int LEAD_CLKS  = 2,
  parameter int HI_BITS    = 14,
  parameter int LO_BITS    = 12,
  parameter int OUT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode12_i,
  input  logic             sdo_i,
  output logic             conv_o,
  output logic             sck_o,
  output logic             busy_o,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  localparam int CW      = HALF_DIV > 1 ? $clog2(HALF_DIV) : 1;
  localparam int LAST_H  = 2*FRAME_CLKS + 1;
  localparam int HW      = $clog2(LAST_H + 1);
  localparam int FIRST_K = LEAD_CLKS + 1;

  logic               busy_q, m12_q;
  logic [CW-1:0]      cnt_q;
  logic [HW-1:0]      h_q;
  logic [HI_BITS-1:0] sh_q;

  wire              half_end = cnt_q == CW'(HALF_DIV-1);
  wire [HW-1:0]     k        = h_q >> 1;
  wire [HW-1:0]     nb       = m12_q ? HW'(LO_BITS) : HW'(HI_BITS);
  wire              fall     = busy_q && half_end && !h_q[0] && h_q >= HW'(2);
  wire              take     = fall && k >= HW'(FIRST_K) && k < HW'(FIRST_K) + nb;
  wire              last     = take && k == HW'(FIRST_K) + nb - HW'(1);
  wire [HI_BITS-1:0] sh_d    = {sh_q[HI_BITS-2:0], sdo_i};

  assign busy_o = busy_q;
  assign conv_o = busy_q && h_q < HW'(2);
  assign sck_o  = busy_q && h_q >= HW'(2) && !h_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      m12_q   <= 1'b0;
      cnt_q   <= '0;
      h_q     <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          m12_q  <= mode12_i;
          cnt_q  <= '0;
          h_q    <= '0;
          sh_q   <= '0;
        end
      end else begin
        if (take) sh_q <= sh_d;
        if (last) begin
          data_o  <= OUT_W'(sh_d);
          valid_o <= 1'b1;
        end
        if (half_end) begin
          cnt_q <= '0;
          if (h_q == HW'(LAST_H)) busy_q <= 1'b0;
          else h_q <= h_q + HW'(1);
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

module adc_serial_reader_chk #(
  parameter int HI_BITS = 14,
  parameter int LO_BITS = 12,
  parameter int OUT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             conv_o,
  input logic             sck_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic             m12_q,
  input logic [OUT_W-1:0] data_o
);
  a_r2_sck_low_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> !sck_o);
  a_r2_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> conv_o);
  a_r3_sck_follows_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> sck_o);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!conv_o && !sck_o));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && conv_o && start_i) |=> busy_o);
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r5_zero_ext_14: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !m12_q) |-> (data_o >> HI_BITS) == '0);
  a_r6_zero_ext_12: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && m12_q) |-> (data_o >> LO_BITS) == '0);
endmodule

bind adc_serial_reader adc_serial_reader_chk #(
  .HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .conv_o(conv_o), .sck_o(sck_o),
  .busy_o(busy_o), .valid_o(valid_o), .m12_q(m12_q), .data_o(data_o)
);

// File: tb/sim_adc_serial_reader.sv
module sim_adc_serial_reader;
  localparam int HALF  = 2;
  localparam int FRAME = 16;

  logic clk = 0, rst_n = 0, start_i = 0, mode12_i = 0, sdo_i = 0;
  logic conv_o, sck_o, busy_o, valid_o;
  logic [15:0] data_o;

  adc_serial_reader #(.HALF_DIV(HALF), .FRAME_CLKS(FRAME)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode12_i(mode12_i), .sdo_i(sdo_i),
    .conv_o(conv_o), .sck_o(sck_o), .busy_o(busy_o), .data_o(data_o), .valid_o(valid_o));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int rises = 0, conv_cyc = 0, valid_cyc = 0;
  int rcnt = 0, nbits = 14;
  logic [13:0] word = '0;
  logic [15:0] got = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // converter model: bit index by rising sck count since strobe rise
  always @(posedge conv_o or posedge sck_o) begin
    if (conv_o) rcnt = 0;
    else begin
      rcnt = rcnt + 1;
      rises++;
      if (rcnt >= 3 && rcnt - 3 < nbits) sdo_i <= word[nbits-1-(rcnt-3)];
      else sdo_i <= 1'($urandom);
    end
  end

  always @(negedge clk) begin
    if (conv_o) conv_cyc++;
    if (valid_o) begin valid_cyc++; got = data_o; end
  end

  function automatic logic [15:0] expect_word(input logic [13:0] w, input int n);
    return (n == 12) ? {4'b0, w[11:0]} : {2'b0, w};
  endfunction

  task automatic frame(input logic [13:0] w, input bit m12, input bit poke, input bit flip);
    @(negedge clk);
    word = w; nbits = m12 ? 12 : 14;
    rises = 0; conv_cyc = 0; valid_cyc = 0;
    mode12_i = m12; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (flip) mode12_i = ~m12;
    check(busy_o == 1, "R8 busy after start", busy_o, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    while (busy_o) @(negedge clk);
    check(conv_cyc == 2*HALF, "R2 strobe cycles", conv_cyc, 2*HALF);
    check(rises == FRAME, "R3 sck rises", rises, FRAME);
    check(valid_cyc == 1, "R7 valid cycles", valid_cyc, 1);
    if (m12) check(got == expect_word(w, 12), flip ? "R9 mode latched" : "R6 12-bit data", got, expect_word(w, 12));
    else     check(got == expect_word(w, 14), flip ? "R9 mode latched" : "R5 14-bit data", got, expect_word(w, 14));
    check(data_o == got, "R7 data held", data_o, got);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy_o == 0 && conv_cyc == 2*HALF, "R8 start while busy ignored", busy_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(conv_o == 0 && sck_o == 0 && busy_o == 0 && valid_o == 0, "R1 reset outputs",
          {conv_o, sck_o, busy_o, valid_o}, 0);
    check(data_o == 0, "R1 reset data", data_o, 0);
    rst_n = 1;
    frame(14'h3fff, 0, 0, 0);   // R5 all ones, upper zero
    frame(14'h3fff, 1, 0, 0);   // R6 all ones, upper zero
    frame(14'h0000, 0, 0, 0);
    frame(14'h2aaa, 0, 0, 0);   // R4 MSB-first ordering
    frame(14'h1555, 1, 0, 0);
    frame(14'h2001, 0, 1, 0);   // R8 start mid-frame
    frame(14'h0abc, 1, 0, 1);   // R9 mode flip after start
    frame(14'h1234, 0, 0, 1);
    for (int i = 0; i < 40; i++) frame(14'($urandom), 1'($urandom), 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule